// File: doc/BRIEF.md
# Bus-Snooping Display Fetch and Sync Controller

This block connects an 8-bit CPU bus to a ROM and a 1 KiB RAM in a small computer that has no video processor. Every bus cycle is decoded by region. ROM reads go to an external ROM port, and RAM reads and writes go to an internal array. Both regions repeat across their part of the address map.

The CPU itself walks through the display area. When it fetches an opcode from the upper half of the map, the block checks the RAM byte that comes back. If that byte is a display byte, the block sends it to a video shifter port with a one-cycle strobe and gives the CPU 0x00 instead, which is a no-operation.

Horizontal and vertical sync do not come from counters inside the block. They come from the types of cycle the CPU runs: I/O reads, I/O writes, interrupt acknowledges and opcode fetches. The interrupt request level follows bit 6 of the CPU's refresh counter and is updated on every opcode fetch.

All outputs are registered on the rising clock edge, and reset is synchronous and active high. The target clock is 3.25 MHz.

Top module: `snoop_video_fetch`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, the outputs are: `hsync`, `vsync`, `csync`, `irq` and `vid_valid` all 0, and `rd_data` = 0xFF.
- R2: The encoding of `cyc_type` is 0 idle, 1 opcode fetch, 2 read, 3 write, 4 I/O in, 5 I/O out, 6 interrupt acknowledge. For a fetch or read with `addr[15:14]`=00, `rd_data` in the next cycle equals `rom_rdata`. `rom_addr` is `addr[12:0]`, so the ROM repeats across the region.
- R3: A write with `addr[14]`=1 stores `wdata` at RAM index `addr[9:0]`. A later read with `addr[14]`=1 and the same low 10 bits returns that byte, whatever the other address bits are.
- R4: A display fetch is an opcode fetch with `addr[15:14]`=11, a stored byte whose bit 6 is 0, and `halted`=0. In the next cycle `rd_data` is 0x00, `vid_byte` is the stored byte, and `vid_valid` is 1 for exactly one cycle.
- R5: If any display-fetch condition fails (bit 6 set, `halted`=1, `addr[15]`=0, or the cycle is a plain read), a RAM-region access returns the stored byte unchanged, and `vid_valid` stays 0.
- R6: An I/O in cycle with `addr[2:0]`=6 sets `vsync`. An I/O out cycle with `addr[2:0]`=7 clears it. I/O cycles with other low address bits leave `vsync` unchanged.
- R7: Every I/O in cycle returns 0xFF on `rd_data`.
- R8: An interrupt acknowledge sets `hsync` and returns 0xFF. The next opcode fetch clears `hsync`, and no other cycle type changes it.
- R9: On each opcode fetch, `irq` becomes 1 when `refresh[6]` is 0 and 0 when it is 1. Other cycle types hold `irq`.
- R10: `csync` equals `hsync` OR `vsync` in every cycle, so it toggles only when that OR changes.
- R11: A read or fetch with `addr[15:14]`=10 returns 0xFF. A write with `addr[14]`=0 leaves the RAM unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_type | input | 3 | CPU bus cycle type (encoding in R2) |
| addr | input | 16 | CPU address |
| refresh | input | 7 | CPU refresh counter value |
| halted | input | 1 | CPU is in the halt state |
| wdata | input | 8 | CPU write data |
| rd_data | output | 8 | Data returned to the CPU, registered |
| rom_addr | output | 13 | ROM index (mirrored address) |
| rom_rdata | input | 8 | ROM data for `rom_addr` |
| vid_valid | output | 1 | One-cycle strobe for a display byte |
| vid_byte | output | 8 | Display byte for the video shifter |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| csync | output | 1 | Composite sync |
| irq | output | 1 | Interrupt request level |

## Verification
The RAM is first loaded with random bytes, so that bit 6 is set in about half of the locations. Random cycles of every type then run with random addresses, refresh values and halt flags. This separates display fetches from pass-through fetches, and separates RAM mirrors from ROM mirrors. Directed sequences then cover the remaining corners:
- each display-fetch condition is made to fail one at a time;
- a write to the unmapped region is followed by a read-back through a mirror;
- vsync is set, then hsync, then vsync is cleared, then hsync is cleared, so `csync` is seen to stay high until both syncs fall;
- refresh values 0x3F and 0x40 land on either side of bit 6.

// File: rtl/snoop_video_fetch.sv
module snoop_video_fetch #(
  parameter int ADDR_W = 16,
  parameter int ROM_AW = 13,
  parameter int RAM_AW = 10,
  parameter int REF_W  = 7,
  parameter int IRQ_BIT = 6,
  parameter int DISP_BIT = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        cyc_type,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REF_W-1:0]  refresh,
  input  logic              halted,
  input  logic [7:0]        wdata,
  output logic [7:0]        rd_data,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [7:0]        rom_rdata,
  output logic              vid_valid,
  output logic [7:0]        vid_byte,
  output logic              hsync,
  output logic              vsync,
  output logic              csync,
  output logic              irq
);
  localparam logic [2:0] C_FETCH = 3'd1, C_READ = 3'd2, C_WRITE = 3'd3,
                         C_IOIN = 3'd4, C_IOOUT = 3'd5, C_INTA = 3'd6;
  localparam int RAM_D = 1 << RAM_AW;
  localparam int HI = ADDR_W - 1;
  localparam int MID = ADDR_W - 2;

  logic [7:0] mem [RAM_D];
  logic [7:0] ram_q;
  logic       rom_sel, ram_sel, is_fetch, is_rd, disp;
  logic       hs_n, vs_n;

  assign rom_addr = addr[ROM_AW-1:0];
  assign rom_sel  = !addr[HI] && !addr[MID];
  assign ram_sel  = addr[MID];
  assign ram_q    = mem[addr[RAM_AW-1:0]];
  assign is_fetch = cyc_type == C_FETCH;
  assign is_rd    = is_fetch || cyc_type == C_READ;
  assign disp     = is_fetch && ram_sel && addr[HI] && !ram_q[DISP_BIT] && !halted;

  assign hs_n = (cyc_type == C_INTA) ? 1'b1 : is_fetch ? 1'b0 : hsync;
  assign vs_n = (cyc_type == C_IOIN  && addr[2:0] == 3'd6) ? 1'b1 :
                (cyc_type == C_IOOUT && addr[2:0] == 3'd7) ? 1'b0 : vsync;

  always_ff @(posedge clk)
    if (!rst && cyc_type == C_WRITE && ram_sel)
      mem[addr[RAM_AW-1:0]] <= wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync <= 1'b0;
      vsync <= 1'b0;
      csync <= 1'b0;
      irq <= 1'b0;
      vid_valid <= 1'b0;
      vid_byte <= 8'h00;
      rd_data <= 8'hFF;
    end else begin
      hsync <= hs_n;
      vsync <= vs_n;
      csync <= hs_n | vs_n;
      vid_valid <= disp;
      if (is_fetch) irq <= !refresh[IRQ_BIT];
      if (disp) vid_byte <= ram_q;
      if (is_rd) begin
        if (rom_sel)      rd_data <= rom_rdata;
        else if (disp)    rd_data <= 8'h00;
        else if (ram_sel) rd_data <= ram_q;
        else              rd_data <= 8'hFF;
      end else if (cyc_type == C_IOIN || cyc_type == C_INTA) begin
        rd_data <= 8'hFF;
      end
    end
  end
endmodule

// File: rtl/snoop_video_fetch_chk.sv
module snoop_video_fetch_chk (
  input logic        clk,
  input logic        rst,
  input logic [2:0]  cyc_type,
  input logic [15:0] addr,
  input logic [6:0]  refresh,
  input logic        halted,
  input logic [7:0]  rd_data,
  input logic        vid_valid,
  input logic        hsync,
  input logic        vsync,
  input logic        csync,
  input logic        irq
);
  assert_csync_or_R10: assert property (@(posedge clk) disable iff (rst)
    csync == (hsync | vsync));
  assert_inta_sets_R8: assert property (@(posedge clk) disable iff (rst)
    cyc_type == 3'd6 |=> hsync && rd_data == 8'hFF);
  assert_fetch_clears_R8: assert property (@(posedge clk) disable iff (rst)
    cyc_type == 3'd1 |=> !hsync);
  assert_irq_level_R9: assert property (@(posedge clk) disable iff (rst)
    cyc_type == 3'd1 |=> irq == !$past(refresh[6]));
  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (rst)
    cyc_type != 3'd1 |=> $stable(irq));
  assert_vid_cause_R4: assert property (@(posedge clk) disable iff (rst)
    vid_valid |-> $past(cyc_type) == 3'd1 && $past(addr[15:14]) == 2'b11 && !$past(halted));
  assert_vid_nop_R4: assert property (@(posedge clk) disable iff (rst)
    vid_valid |-> rd_data == 8'h00);
  assert_ioin_ff_R7: assert property (@(posedge clk) disable iff (rst)
    cyc_type == 3'd4 |=> rd_data == 8'hFF);
  assert_vsync_set_R6: assert property (@(posedge clk) disable iff (rst)
    cyc_type == 3'd4 && addr[2:0] == 3'd6 |=> vsync);
  assert_vsync_clr_R6: assert property (@(posedge clk) disable iff (rst)
    cyc_type == 3'd5 && addr[2:0] == 3'd7 |=> !vsync);
endmodule

bind snoop_video_fetch snoop_video_fetch_chk chk_i (
  .clk(clk), .rst(rst), .cyc_type(cyc_type), .addr(addr), .refresh(refresh),
  .halted(halted), .rd_data(rd_data), .vid_valid(vid_valid), .hsync(hsync),
  .vsync(vsync), .csync(csync), .irq(irq)
);

// File: tb/snoop_video_fetch_tb.sv
module snoop_video_fetch_tb_top;
  localparam int CLK_P = 10;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0]  cyc_type = 3'd0;
  logic [15:0] addr = 16'h0;
  logic [6:0]  refresh = 7'h0;
  logic        halted = 1'b0;
  logic [7:0]  wdata = 8'h0;
  logic [7:0]  rd_data, rom_rdata, vid_byte;
  logic [12:0] rom_addr;
  logic        vid_valid, hsync, vsync, csync, irq;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [7:0] ram_m [1024];
  logic [7:0] e_rd = 8'hFF, e_vb = 8'h00;
  logic e_vv = 0, e_hs = 0, e_vs = 0, e_irq = 0;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] romf(input logic [12:0] a);
    return a[7:0] ^ {3'b000, a[12:8]} ^ 8'h3C;
  endfunction
  assign rom_rdata = romf(rom_addr);

  snoop_video_fetch dut_i (
    .clk(clk), .rst(rst), .cyc_type(cyc_type), .addr(addr), .refresh(refresh),
    .halted(halted), .wdata(wdata), .rd_data(rd_data), .rom_addr(rom_addr),
    .rom_rdata(rom_rdata), .vid_valid(vid_valid), .vid_byte(vid_byte),
    .hsync(hsync), .vsync(vsync), .csync(csync), .irq(irq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  task automatic step(input logic [2:0] t, input logic [15:0] a, input logic [7:0] w,
                      input logic [6:0] r, input logic h);
    string rtag;
    logic [7:0] b;
    @(negedge clk);
    cyc_type = t; addr = a; wdata = w; refresh = r; halted = h;
    @(posedge clk);
    e_vv = 0;
    rtag = "R2";
    case (t)
      3'd1, 3'd2: begin
        if (t == 3'd1) begin e_hs = 0; e_irq = !r[6]; end
        if (a[15:14] == 2'b00) begin e_rd = romf(a[12:0]); rtag = "R2"; end
        else if (a[14]) begin
          b = ram_m[a[9:0]];
          if (t == 3'd1 && a[15] && !b[6] && !h) begin
            e_rd = 8'h00; e_vv = 1; e_vb = b; rtag = "R4";
          end else begin e_rd = b; rtag = "R5"; end
        end else begin e_rd = 8'hFF; rtag = "R11"; end
      end
      3'd3: if (a[14]) ram_m[a[9:0]] = w;
      3'd4: begin if (a[2:0] == 3'd6) e_vs = 1; e_rd = 8'hFF; rtag = "R7"; end
      3'd5: if (a[2:0] == 3'd7) e_vs = 0;
      3'd6: begin e_hs = 1; e_rd = 8'hFF; rtag = "R8"; end
      default: ;
    endcase
    #1;
    chk(rtag, rd_data, e_rd);
    chk("R4", {7'b0, vid_valid}, {7'b0, e_vv});
    if (e_vv) chk("R4", vid_byte, e_vb);
    chk("R8", {7'b0, hsync}, {7'b0, e_hs});
    chk("R6", {7'b0, vsync}, {7'b0, e_vs});
    chk("R9", {7'b0, irq}, {7'b0, e_irq});
    chk("R10", {7'b0, csync}, {7'b0, e_hs | e_vs});
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > WATCHDOG) begin
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    void'($urandom(32'd20240601));
    repeat (2) @(posedge clk);
    #1;
    chk("R1", rd_data, 8'hFF);
    chk("R1", {3'b0, hsync, vsync, csync, irq, vid_valid}, 8'h00);
    @(negedge clk); rst = 0;
    @(posedge clk); #1;
    chk("R1", {3'b0, hsync, vsync, csync, irq, vid_valid}, 8'h00);

    // preload RAM through a mirror (R3)
    for (int i = 0; i < 1024; i++)
      step(3'd3, 16'h4000 | 16'(i) | (16'($urandom) & 16'hBC00), 8'($urandom), 7'h0, 1'b0);

    // directed: display fetch and pass-through (R4, R5, R3)
    step(3'd3, 16'hC005, 8'h12, 7'h00, 1'b0);
    step(3'd1, 16'hC005, 8'h00, 7'h00, 1'b0);   // R4 display
    step(3'd0, 16'h0000, 8'h00, 7'h00, 1'b0);   // R4 strobe drops
    step(3'd1, 16'hC005, 8'h00, 7'h00, 1'b1);   // R5 halted
    step(3'd1, 16'h4005, 8'h00, 7'h00, 1'b0);   // R5 bit15 clear
    step(3'd2, 16'hF805, 8'h00, 7'h00, 1'b0);   // R5 plain read, R3 mirror
    step(3'd3, 16'h7C05, 8'h52, 7'h00, 1'b0);
    step(3'd1, 16'hC005, 8'h00, 7'h00, 1'b0);   // R5 bit6 set
    // unmapped write ignored, unmapped read (R11)
    step(3'd3, 16'h8005, 8'hAA, 7'h00, 1'b0);
    step(3'd3, 16'h0005, 8'hAB, 7'h00, 1'b0);
    step(3'd2, 16'h4005, 8'h00, 7'h00, 1'b0);   // R11 still 0x52
    step(3'd2, 16'h8123, 8'h00, 7'h00, 1'b0);   // R11 reads 0xFF
    step(3'd2, 16'h3FFF, 8'h00, 7'h00, 1'b0);   // R2 ROM mirror
    // sync ordering (R6, R8, R10)
    step(3'd4, 16'h00FE, 8'h00, 7'h00, 1'b0);
    step(3'd6, 16'h0000, 8'h00, 7'h00, 1'b0);
    step(3'd5, 16'h00FF, 8'h00, 7'h00, 1'b0);
    step(3'd2, 16'h0010, 8'h00, 7'h00, 1'b0);
    step(3'd1, 16'h0010, 8'h00, 7'h3F, 1'b0);   // R9 irq high
    step(3'd4, 16'h0005, 8'h00, 7'h3F, 1'b0);   // R6 no effect
    step(3'd5, 16'h0006, 8'h00, 7'h3F, 1'b0);
    step(3'd1, 16'h0011, 8'h00, 7'h40, 1'b0);   // R9 irq low

    // constrained random
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] t;
      logic [15:0] a;
      t = 3'($urandom_range(0, 6));
      a = 16'($urandom);
      if (($urandom & 3) == 0) a[2:0] = 3'($urandom_range(6, 7));
      step(t, a, 8'($urandom), 7'($urandom), ($urandom & 7) == 0);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule